// File: doc/BRIEF.md
# RMII Receive Byte Assembler

This block sits directly behind the two-bit receive path of a reduced media-independent interface. Each clock it takes one dibit together with the shared carrier/valid line. It waits for a run of preamble dibits followed by the start-of-frame delimiter, then packs every following group of four dibits into a byte and strobes it out for one cycle. Downstream logic (checksum, address match, buffer writer) sees only payload bytes.

The carrier/valid line may toggle at nibble boundaries near the end of a frame, because the PHY has lost carrier but still holds buffered data. The assembler keeps accepting dibits while the line is low on the first dibit of a nibble. It closes the frame only when the line is low on the second dibit of a nibble. Any partly filled byte is then dropped and the block goes back to looking for a preamble.

Top module: `rmii_rx_assembler`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rx_byte_stb` is low.
- R2: A preamble is one or more dibits with `rx_pair` = 2'b01 while `carrier_valid` is high. Any length from 10 to 40 dibits, followed by the delimiter, starts a frame whose bytes are all delivered.
- R3: The delimiter is a single dibit `rx_pair` = 2'b11 with `carrier_valid` high, directly after a preamble dibit. The first payload dibit is the one after it. A 2'b11 dibit with no preamble before it starts no frame.
- R4: Four payload dibits make one byte. The first dibit goes to bits [1:0], the second to [3:2], the third to [5:4] and the fourth to [7:6]. `rx_pair[0]` is the lower bit of each pair.
- R5: `rx_byte_stb` is high for exactly one cycle per byte. This is the cycle after the edge that samples the fourth dibit, and `rx_byte` holds the byte in that cycle.
- R6: Inside a frame, a dibit taken with `carrier_valid` low at an even slot (first dibit of a nibble) is still accepted as data. Bytes sent with this toggling are delivered correctly, including the last one.
- R7: Inside a frame, `carrier_valid` low at an odd slot (second dibit of a nibble) ends the frame. A partly filled byte is discarded, and a new frame can follow straight away.
- R8: A preamble that ends without a delimiter produces no bytes.
- R9: A dibit other than 2'b01 or 2'b11 during the preamble, with `carrier_valid` high, abandons the preamble. A delimiter after it starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one dibit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_valid | input | 1 | Shared carrier-sense / data-valid line |
| rx_pair | input | PAIR_W (2) | Received dibit, bit 0 is the lower data bit |
| rx_byte | output | DATA_W (8) | Assembled payload byte |
| rx_byte_stb | output | 1 | One-cycle strobe marking a new byte on `rx_byte` |

## Verification
Preamble lengths are swept over every value from 10 to 40. This separates a delimiter search that tolerates any run length from one that counts to a fixed value. One frame carries all 256 byte values in order, which exposes any swapped pair or reversed dibit order. Frames with a toggling tail, with one to six bytes, are contrasted with frames that drop carrier at odd and late slots: the first kind must deliver every byte and the second must discard the partial byte. The last pattern group is a bare delimiter, a broken preamble and a preamble with no delimiter, each followed by filler that contains no preamble code. All three must stay silent.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PRE  = 2'd1,
    ST_PAY  = 2'd2
  } hunt_state_t;
endpackage

// File: rtl/rmii_rx_sfd_fsm.sv
module rmii_rx_sfd_fsm
  import rmii_rx_pkg::*;
#(
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_valid,
  input  logic [PAIR_W-1:0] rx_pair,
  input  logic              odd_phase,
  output hunt_state_t       state_q,
  output logic              in_payload
);
  localparam logic [PAIR_W-1:0] CODE_PRE = PAIR_W'(1);
  localparam logic [PAIR_W-1:0] CODE_SFD = {PAIR_W{1'b1}};

  hunt_state_t state_d;
  logic        state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HUNT: if (carrier_valid && rx_pair == CODE_PRE) state_d = ST_PRE;
      ST_PRE: begin
        if (!carrier_valid)            state_d = ST_HUNT;
        else if (rx_pair == CODE_SFD)  state_d = ST_PAY;
        else if (rx_pair != CODE_PRE)  state_d = ST_HUNT;
      end
      ST_PAY:  if (!carrier_valid && odd_phase) state_d = ST_HUNT;
      default: state_d = ST_HUNT;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_HUNT;
    else if (state_en) state_q <= state_d;
  end

  assign in_payload = (state_q == ST_PAY);
endmodule

// File: rtl/rmii_rx_dibit_packer.sv
module rmii_rx_dibit_packer #(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_payload,
  input  logic              carrier_valid,
  input  logic [PAIR_W-1:0] rx_pair,
  output logic              odd_phase,
  output logic [DATA_W-1:0] byte_q,
  output logic              byte_stb
);
  localparam int SLOTS   = DATA_W / PAIR_W;
  localparam int CNT_W   = $clog2(SLOTS);
  localparam int SHIFT_W = DATA_W - PAIR_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0]   slot_q, slot_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0]  assembled;
  logic               accept, last_slot, byte_en, stb_d;

  assign odd_phase = slot_q[0];
  assign accept    = in_payload && !(odd_phase && !carrier_valid);
  assign last_slot = (slot_q == LAST);
  assign assembled = {rx_pair, shift_q};
  assign shift_d   = {rx_pair, shift_q[SHIFT_W-1:PAIR_W]};
  assign byte_en   = accept && last_slot;
  assign stb_d     = byte_en;

  always_comb begin
    if (!accept)        slot_d = '0;
    else if (last_slot) slot_d = '0;
    else                slot_d = slot_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shift_q <= '0;
    else if (accept) shift_q <= shift_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= assembled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byte_stb <= 1'b0;
    else        byte_stb <= stb_d;
  end
endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler
  import rmii_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_valid,
  input  logic [PAIR_W-1:0] rx_pair,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_byte_stb
);
  hunt_state_t fsm_state;
  logic        in_payload;
  logic        odd_phase;

  rmii_rx_sfd_fsm #(.PAIR_W(PAIR_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .carrier_valid (carrier_valid),
    .rx_pair       (rx_pair),
    .odd_phase     (odd_phase),
    .state_q       (fsm_state),
    .in_payload    (in_payload)
  );

  rmii_rx_dibit_packer #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_pack (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_payload    (in_payload),
    .carrier_valid (carrier_valid),
    .rx_pair       (rx_pair),
    .odd_phase     (odd_phase),
    .byte_q        (rx_byte),
    .byte_stb      (rx_byte_stb)
  );
endmodule

// File: rtl/rmii_rx_assembler_chk.sv
module rmii_rx_assembler_chk
  import rmii_rx_pkg::*;
#(
  parameter int PAIR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              carrier_valid,
  input logic [PAIR_W-1:0] rx_pair,
  input logic              rx_byte_stb,
  input logic              in_payload,
  input hunt_state_t       fsm_state
);
  AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_stb |=> !rx_byte_stb); // R5

  AST_STB_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_stb |-> $past(in_payload)); // R8

  AST_ENTRY_ON_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_payload) |-> $past(carrier_valid && rx_pair == {PAIR_W{1'b1}})); // R3

  AST_ENTRY_AFTER_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_payload) |-> $past(fsm_state == ST_PRE)); // R2

  AST_EXIT_ON_CARRIER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_payload) |-> $past(!carrier_valid)); // R7
endmodule

bind rmii_rx_assembler rmii_rx_assembler_chk #(.PAIR_W(PAIR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .carrier_valid (carrier_valid),
  .rx_pair       (rx_pair),
  .rx_byte_stb   (rx_byte_stb),
  .in_payload    (in_payload),
  .fsm_state     (fsm_state)
);

// File: tb/rmii_rx_assembler_bench.sv
`timescale 1ns/1ps
module rmii_rx_assembler_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv = 1'b0;
  logic [1:0] pair = 2'b00;
  logic [7:0] rx_byte;
  logic       stb;

  int checks = 0;
  int fails = 0;
  int got_n = 0;
  int pulse_err = 0;
  bit prev_stb = 1'b0;
  bit done = 1'b0;
  logic [7:0] got   [0:511];
  logic [7:0] exp_b [0:511];

  always #4 clk = ~clk;

  rmii_rx_assembler u_rmii_rx_assembler (
    .clk(clk), .rst_n(rst_n), .carrier_valid(cv), .rx_pair(pair),
    .rx_byte(rx_byte), .rx_byte_stb(stb)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (stb) begin
        if (got_n < 512) got[got_n] = rx_byte;
        got_n = got_n + 1;
        if (prev_stb) pulse_err = pulse_err + 1;
      end
      prev_stb = stb;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(input logic c, input logic [1:0] p);
    @(negedge clk);
    cv = c;
    pair = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'b00);
  endtask

  function automatic logic [7:0] val(input int seed, input int i);
    if (seed < 0) return i[7:0];
    return 8'((seed * 29 + i * 53 + 7) & 255);
  endfunction

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 2'b01);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit toggle);
    for (int k = 0; k < 4; k++) drive(!(toggle && (k % 2 == 0)), b[2*k +: 2]);
  endtask

  task automatic compare(input string tag, input int nexp);
    check(got_n == nexp, tag, got_n, nexp);
    for (int i = 0; i < nexp && i < got_n; i++)
      check(got[i] == exp_b[i], tag, got[i], exp_b[i]);
  endtask

  task automatic run_frame(input int pre_len, input int nbytes, input int seed,
                           input bit tail, input string tag);
    got_n = 0;
    preamble(pre_len);
    drive(1'b1, 2'b11);
    for (int i = 0; i < nbytes; i++) begin
      exp_b[i] = val(seed, i);
      send_byte(exp_b[i], tail && (i >= nbytes - 2));
    end
    idle(6);
    compare(tag, nbytes);
  endtask

  // filler with no preamble code: dibits 00,10,00,10
  task automatic filler(input int nbytes);
    for (int i = 0; i < nbytes; i++) send_byte(8'h88, 1'b0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(stb == 1'b0, "R1 stb in reset", stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stb == 1'b0, "R1 stb after release", stb, 0);
    idle(2);

    // R2 preamble length sweep
    for (int L = 10; L <= 40; L++) run_frame(L, 3, L, 1'b0, "R2 preamble sweep");

    // R4 all byte values, order of dibits
    run_frame(16, 256, -1, 1'b0, "R4 byte values");

    // R6 toggling carrier near end of frame
    for (int n = 1; n <= 6; n++) run_frame(20, n, 100 + n, 1'b1, "R6 toggle tail");

    // R5 latency and width of strobe
    got_n = 0;
    preamble(10);
    drive(1'b1, 2'b11);
    send_byte(8'hA5, 1'b0);
    @(negedge clk);
    check(stb == 1'b1, "R5 strobe after fourth dibit", stb, 1);
    check(rx_byte == 8'hA5, "R5 byte value", rx_byte, 8'hA5);
    cv = 1'b0;
    @(negedge clk);
    check(stb == 1'b0, "R5 strobe one cycle", stb, 0);
    idle(4);
    check(got_n == 1, "R5 single strobe count", got_n, 1);

    // R7 carrier low at odd slot ends frame and drops partial byte
    got_n = 0;
    preamble(12);
    drive(1'b1, 2'b11);
    exp_b[0] = 8'h3C; exp_b[1] = 8'hD2;
    send_byte(8'h3C, 1'b0);
    send_byte(8'hD2, 1'b0);
    drive(1'b1, 2'b11);
    drive(1'b0, 2'b01);
    idle(4);
    compare("R7 end at slot 1", 2);
    got_n = 0;
    preamble(12);
    drive(1'b1, 2'b11);
    send_byte(8'h3C, 1'b0);
    send_byte(8'hD2, 1'b0);
    drive(1'b1, 2'b10);
    drive(1'b1, 2'b01);
    drive(1'b1, 2'b11);
    drive(1'b0, 2'b11);
    idle(4);
    compare("R7 end at slot 3", 2);
    run_frame(11, 5, 77, 1'b0, "R7 next frame");

    // R3 delimiter with no preamble
    got_n = 0;
    drive(1'b1, 2'b11);
    filler(3);
    idle(4);
    check(got_n == 0, "R3 bare delimiter", got_n, 0);

    // R9 broken preamble
    got_n = 0;
    preamble(12);
    drive(1'b1, 2'b00);
    drive(1'b1, 2'b11);
    filler(3);
    idle(4);
    check(got_n == 0, "R9 broken preamble", got_n, 0);
    got_n = 0;
    preamble(12);
    drive(1'b1, 2'b10);
    drive(1'b1, 2'b11);
    filler(3);
    idle(4);
    check(got_n == 0, "R9 broken preamble 10", got_n, 0);

    // R8 preamble without delimiter
    got_n = 0;
    preamble(20);
    idle(2);
    filler(2);
    idle(4);
    check(got_n == 0, "R8 no delimiter", got_n, 0);

    check(pulse_err == 0, "R5 no back-to-back strobes", pulse_err, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule